// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory with a flow-through read path. Any mix of reads and writes runs at one transfer per clock. Address, control, the three chip enables and the burst mode are registered on the rising clock edge. A read returns its word in the clock cycle that follows the edge which registered it, through a combinational path from the registered address into the array. A write takes its data and lane selects one active edge after its address. The write bus and the read bus therefore never compete, and a read can follow a write with no idle cycle between them.

Captured write data is held in a one-entry write buffer. The buffer is committed to the array when the next write's data arrives. A read whose address matches the buffer gets the buffered lanes merged over the array word. Bursts of four words step the low two address bits in either linear or interleaved order. A load/advance input continues the current burst without a new address. An active-low clock enable freezes every register. The read data port carries a separate drive-enable flag, which stands in for a three-state data bus.

Top module: `zft_flow_sram`

## Requirements
- R1: While clk_en_n is high, rising clock edges are ignored. The registered access, the burst position and the write buffer all hold, and the outputs keep their values.
- R2: A load cycle (adv_ld=0) starts an access only when cs_a_n=0, cs_b=1 and cs_c_n=0. wr_n=0 selects a write and wr_n=1 selects a read. A load with any enable inactive is a deselect: nothing is written and rdata_oe is 0 in the following cycle.
- R3: In the cycle right after the edge that registers a read, with oe_n low, rdata_oe is 1 and rdata holds the addressed word.
- R4: Write data and lane_wr_n are sampled at the first active edge after the write's address edge. Lane i is bits 9i+8 down to 9i and is written only when lane_wr_n[i]=0. The other lanes keep their old contents.
- R5: In the cycle that follows a registered write, rdata_oe is 0 whatever the value of oe_n.
- R6: oe_n high forces rdata_oe to 0 at once, with no clock edge needed. rdata reads 0 whenever rdata_oe is 0.
- R7: A read of the address held in the write buffer returns the buffered lanes merged over the stored word. This includes a read issued in the very next cycle after a write's data.
- R8: Reads and writes in any order, including strict alternation, complete one per clock with no idle cycle.
- R9: An advance cycle (adv_ld=1) moves the burst position by one and keeps the access type. It ignores the chip enables, wr_n and addr. An advance after a deselect stays deselected.
- R10: The burst order is sampled at load (order_sel=0 linear, 1 interleaved). Linear order gives the low two address bits as base+count mod 4. Interleaved order gives base XOR count. The upper bits stay fixed.
- R11: After reset no access is active, no write is buffered and rdata_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 1 advances the burst, 0 loads a new access |
| wr_n | input | 1 | 0 for write, 1 for read (load cycles) |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Per-lane write selects, active low, sampled in the data phase |
| wdata | input | LANES*LANE_W | Write data, sampled in the data phase |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data bus drive enable |

## Verification
A wrong access type or a missed deselect shows at the ports in the very next cycle: rdata_oe is set when it should be off, or the reverse. A wrong burst count or order shows as a wrong word on the next advance cycle of a read burst. A write buffer that is stale, misaddressed or committed with the wrong lane mask shows only when that address is read. The bench therefore reads every written location back, both immediately after the write (through forwarding) and after later writes have forced a commit. A clock enable that fails to freeze state shows as a changed word or a lost write once the clock resumes.

// File: rtl/zft_pkg.sv
package zft_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_t;

  // Low two address bits for a given burst position.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

  // Chip select: all three enables must be active.
  function automatic logic chip_sel(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/zft_ctrl.sv
module zft_ctrl
  import zft_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          sel,
  input  logic          adv,
  input  logic          wr_n,
  input  logic          ilv_in,
  input  logic [AW-1:0] addr,
  output acc_kind_t     kind,
  output logic [AW-1:0] eff_addr
);

  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          ilv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= ACC_IDLE;
      base <= '0;
      cnt  <= '0;
      ilv  <= 1'b0;
    end else if (ce) begin
      if (!adv) begin
        if (sel) begin
          kind <= wr_n ? ACC_RD : ACC_WR;
          base <= addr;
          cnt  <= '0;
          ilv  <= ilv_in;
        end else begin
          kind <= ACC_IDLE;
        end
      end else if (kind != ACC_IDLE) begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  assign eff_addr = {base[AW-1:2], burst_low(base[1:0], cnt, ilv)};

  // R1
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(kind) && $stable(cnt) && $stable(base)));

  // R9
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && kind != ACC_IDLE) |=> (cnt == $past(cnt) + 2'd1 && kind == $past(kind)));

  // R2
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !adv && !sel) |=> (kind == ACC_IDLE));

endmodule

// File: rtl/zft_wbuf.sv
module zft_wbuf #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                cap,
  input  logic [AW-1:0]       cap_addr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [LANES-1:0]    lane_n,
  input  logic [AW-1:0]       rd_addr,
  input  logic [LANES*LW-1:0] mem_word,
  output logic                commit,
  output logic [AW-1:0]       buf_addr,
  output logic [LANES*LW-1:0] buf_data,
  output logic [LANES-1:0]    buf_mask,
  output logic                hit,
  output logic [LANES*LW-1:0] fwd_word
);

  logic buf_valid;

  assign commit = ce && cap && buf_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
      buf_mask  <= '0;
    end else if (ce && cap) begin
      buf_valid <= 1'b1;
      buf_addr  <= cap_addr;
      buf_data  <= wdata;
      buf_mask  <= ~lane_n;
    end
  end

  assign hit = buf_valid && (buf_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign fwd_word[g*LW +: LW] = (hit && buf_mask[g]) ? buf_data[g*LW +: LW]
                                                       : mem_word[g*LW +: LW];
  end

  // R4
  data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cap) |=> (buf_valid && buf_addr == $past(cap_addr) && buf_data == $past(wdata)));

endmodule

// File: rtl/zft_mem.sv
module zft_mem #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [LANES-1:0]    wmask,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[g]) arr[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = arr[raddr];
  end

endmodule

// File: rtl/zft_flow_sram.sv
module zft_flow_sram
  import zft_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    adv_ld,
  input  logic                    wr_n,
  input  logic                    order_sel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int DW = LANES * LANE_W;

  logic              ce;
  logic              sel;
  acc_kind_t         kind;
  logic [ADDR_W-1:0] eff_addr;
  logic              wr_phase;
  logic              commit;
  logic [ADDR_W-1:0] buf_addr;
  logic [DW-1:0]     buf_data;
  logic [LANES-1:0]  buf_mask;
  logic              hit;
  logic [DW-1:0]     mem_word;
  logic [DW-1:0]     fwd_word;

  assign ce       = !clk_en_n;
  assign sel      = chip_sel(cs_a_n, cs_b, cs_c_n);
  assign wr_phase = (kind == ACC_WR);

  zft_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sel(sel), .adv(adv_ld),
    .wr_n(wr_n), .ilv_in(order_sel), .addr(addr),
    .kind(kind), .eff_addr(eff_addr)
  );

  zft_wbuf #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .ce(ce), .cap(wr_phase), .cap_addr(eff_addr),
    .wdata(wdata), .lane_n(lane_wr_n), .rd_addr(eff_addr), .mem_word(mem_word),
    .commit(commit), .buf_addr(buf_addr), .buf_data(buf_data), .buf_mask(buf_mask),
    .hit(hit), .fwd_word(fwd_word)
  );

  zft_mem #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_mem (
    .clk(clk), .we(commit), .waddr(buf_addr), .wdata(buf_data), .wmask(buf_mask),
    .raddr(eff_addr), .rdata(mem_word)
  );

  assign rdata_oe = (kind == ACC_RD) && !oe_n;
  assign rdata    = rdata_oe ? fwd_word : '0;

  // R5
  write_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |-> !rdata_oe);

  // R7
  forward_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && hit && (&buf_mask)) |-> (rdata == buf_data));

endmodule

// File: tb/sim_zft_flow_sram.sv
module sim_zft_flow_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b0;
  logic        cs_a_n = 1'b1;
  logic        cs_b = 1'b0;
  logic        cs_c_n = 1'b1;
  logic        adv_ld = 1'b0;
  logic        wr_n = 1'b1;
  logic        order_sel = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [35:0] wdata = '0;
  logic        oe_n = 1'b0;
  logic [35:0] rdata;
  logic        rdata_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  zft_flow_sram u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .adv_ld(adv_ld), .wr_n(wr_n), .order_sel(order_sel),
    .addr(addr), .lane_wr_n(lane_wr_n), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // Bench-side model: 0 idle, 1 read, 2 write
  logic [35:0] ref_m [64];
  int          m_kind = 0;
  logic [5:0]  m_base = '0;
  logic [1:0]  m_cnt  = '0;
  bit          m_ilv  = 1'b0;
  int          drop_idx = 1;

  function automatic logic [5:0] m_addr();
    logic [1:0] lo;
    if (m_ilv) lo = m_base[1:0] ^ m_cnt;
    else       lo = m_base[1:0] + m_cnt;
    return {m_base[5:2], lo};
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive, update model, wait past the edge, compare outputs.
  task automatic cyc(input string tag, input bit ce, input bit ld, input bit selok,
                     input bit wr, input logic [5:0] a, input bit ilv,
                     input logic [35:0] wd, input logic [3:0] ln);
    logic [5:0] pa;
    logic [35:0] e;
    clk_en_n  = !ce;
    adv_ld    = !ld;
    cs_a_n    = !(selok || drop_idx != 0);
    cs_b      =  (selok || drop_idx != 1);
    cs_c_n    = !(selok || drop_idx != 2);
    wr_n      = !wr;
    addr      = a;
    order_sel = ilv;
    wdata     = wd;
    lane_wr_n = ln;
    if (ce) begin
      if (m_kind == 2) begin
        pa = m_addr();
        for (int i = 0; i < 4; i++)
          if (!ln[i]) ref_m[pa][i*9 +: 9] = wd[i*9 +: 9];
      end
      if (ld) begin
        if (selok) begin
          m_kind = wr ? 2 : 1; m_base = a; m_cnt = 2'd0; m_ilv = ilv;
        end else m_kind = 0;
      end else if (m_kind != 0) m_cnt = m_cnt + 2'd1;
    end
    @(posedge clk);
    #2;
    if (m_kind == 1 && !oe_n) begin
      e = ref_m[m_addr()];
      chk({tag, " oe"}, rdata_oe == 1'b1, {35'd0, rdata_oe}, 36'd1);
      chk({tag, " data"}, rdata == e, rdata, e);
    end else begin
      chk({tag, " off"}, rdata_oe == 1'b0 && rdata == '0, rdata, 36'd0);
    end
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1, 1, 0, 0, 6'd0, 0, 36'd0, 4'hF);
  endtask

  // R11: reset state
  task automatic t_reset();
    chk("R11 reset oe", rdata_oe == 1'b0 && rdata == '0, rdata, 36'd0);
    cyc("R11 deselect after reset", 1, 1, 0, 0, 6'd0, 0, 36'd0, 4'hF);
  endtask

  // R3, R4: plain write then read, and partial lane write
  task automatic t_basic();
    for (int k = 0; k < 8; k++) begin
      cyc("R4 write load", 1, 1, 1, 1, 6'(k), 0, 36'd0, 4'hF);
      cyc("R5 data phase", 1, 0, 0, 0, 6'd0, 0, 36'h1_2345_6700 + 36'(k * 36'h0111_0101), 4'h0);
    end
    for (int k = 0; k < 8; k++) cyc("R3 read", 1, 1, 1, 0, 6'(k), 0, 36'd0, 4'hF);
    cyc("R4 lane write", 1, 1, 1, 1, 6'd3, 0, 36'd0, 4'hF);
    cyc("R4 lanes 1,3", 1, 0, 0, 0, 6'd0, 0, 36'hF_FFFF_FFFF, 4'b0101);
    idle("R4 gap");
    cyc("R4 lane readback", 1, 1, 1, 0, 6'd3, 0, 36'd0, 4'hF);
  endtask

  // R7, R8: alternating writes and reads with no gap, forwarding
  task automatic t_alternate();
    for (int k = 0; k < 6; k++) begin
      cyc("R8 alt write", 1, 1, 1, 1, 6'd20 + 6'(k), 0, 36'd0, 4'hF);
      cyc("R7 read after write", 1, 1, 1, 0, 6'd20 + 6'(k), 0, 36'hA_0000_0000 + 36'(k * 7919), 4'h0);
    end
    cyc("R7 full write", 1, 1, 1, 1, 6'd30, 0, 36'd0, 4'hF);
    cyc("R7 lane0 write", 1, 1, 1, 1, 6'd30, 0, 36'h9_8765_4321, 4'h0);
    cyc("R7 merged read", 1, 1, 1, 0, 6'd30, 0, 36'h0_0000_01AB, 4'b1110);
    cyc("R8 write after read", 1, 1, 1, 1, 6'd31, 0, 36'd0, 4'hF);
    cyc("R8 write to write", 1, 1, 1, 1, 6'd30, 0, 36'h5_5555_5555, 4'h0);
    cyc("R7 read commit pend", 1, 1, 1, 0, 6'd31, 0, 36'h3_3333_3333, 4'h0);
    cyc("R7 read committed", 1, 1, 1, 0, 6'd30, 0, 36'd0, 4'hF);
  endtask

  // R5, R6: output off during write data phase, async output enable
  task automatic t_output();
    cyc("R3 read for oe", 1, 1, 1, 0, 6'd2, 0, 36'd0, 4'hF);
    oe_n = 1'b1; #1;
    chk("R6 oe_n high off", rdata_oe == 1'b0 && rdata == '0, rdata, 36'd0);
    oe_n = 1'b0; #1;
    chk("R6 oe_n low on", rdata_oe == 1'b1, {35'd0, rdata_oe}, 36'd1);
    cyc("R5 write with oe low", 1, 1, 1, 1, 6'd40, 0, 36'd0, 4'hF);
    cyc("R5 read after write", 1, 1, 1, 0, 6'd40, 0, 36'h7_0707_0707, 4'h0);
  endtask

  // R2: each chip enable dropped in turn blocks a write
  task automatic t_deselect();
    for (int d = 0; d < 3; d++) begin
      drop_idx = d;
      cyc("R2 deselect write", 1, 1, 0, 1, 6'd5, 0, 36'd0, 4'hF);
      cyc("R2 deselect data", 1, 1, 0, 0, 6'd5, 0, 36'hB_AD00_0BAD, 4'h0);
      cyc("R9 advance stays deselected", 1, 0, 0, 0, 6'd5, 0, 36'hB_AD00_0BAD, 4'h0);
      drop_idx = 1;
      cyc("R2 old value kept", 1, 1, 1, 0, 6'd5, 0, 36'd0, 4'hF);
    end
  endtask

  // R1: clock enable freezes everything
  task automatic t_freeze();
    cyc("R1 read before hold", 1, 1, 1, 0, 6'd6, 0, 36'd0, 4'hF);
    cyc("R1 held edge", 0, 1, 1, 1, 6'd7, 0, 36'hD_EAD0_DEAD, 4'h0);
    cyc("R1 held edge 2", 0, 1, 1, 1, 6'd7, 0, 36'hD_EAD0_DEAD, 4'h0);
    cyc("R1 read unchanged", 1, 1, 1, 0, 6'd7, 0, 36'd0, 4'hF);
    cyc("R1 write load", 1, 1, 1, 1, 6'd6, 0, 36'd0, 4'hF);
    cyc("R1 hold in data phase", 0, 1, 1, 0, 6'd0, 0, 36'hE_EEEE_EEEE, 4'h0);
    cyc("R1 data after hold", 1, 1, 1, 0, 6'd6, 0, 36'h1_1111_1111, 4'h0);
  endtask

  // R9, R10: write burst then linear and interleaved read bursts
  task automatic t_burst();
    cyc("R9 burst write load", 1, 1, 1, 1, 6'd12, 0, 36'd0, 4'hF);
    for (int k = 0; k < 3; k++)
      cyc("R9 burst write beat", 1, 0, 0, 0, 6'd50, 0, 36'hC_0000_0000 + 36'(k), 4'h0);
    cyc("R10 interleaved load", 1, 1, 1, 0, 6'd13, 1, 36'hC_0000_0003, 4'h0);
    for (int k = 0; k < 4; k++)
      cyc("R10 interleaved beat", 1, 0, 0, 1, 6'd0, 0, 36'd0, 4'h0);
    cyc("R10 linear load", 1, 1, 1, 0, 6'd14, 0, 36'd0, 4'hF);
    for (int k = 0; k < 4; k++)
      cyc("R10 linear beat", 1, 0, 1, 1, 6'd0, 1, 36'd0, 4'h0);
    cyc("R10 interleaved base 2", 1, 1, 1, 0, 6'd14, 1, 36'd0, 4'hF);
    for (int k = 0; k < 3; k++)
      cyc("R10 interleaved base 2 beat", 1, 0, 0, 0, 6'd0, 0, 36'd0, 4'hF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_alternate();
        t_output();
        t_deselect();
        t_freeze();
        t_burst();
        idle("R2 final idle");
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog expired actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule